// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two independent components each produce a guess for the branch at the fetch address. The first component is a global-history table: the fetch address is hashed with a shift register that holds recent branch outcomes. The second component is a local two-level table: a per-branch history selects one counter inside a set picked by the address. A third table of 2-bit chooser counters, also indexed by the address, selects which component's guess becomes the final answer.

The front end presents an address on the lookup port and receives the final guess, both component guesses and a snapshot of the global history. All of these travel with the branch down the pipeline. When the branch resolves, the back end returns them on the training port together with the real outcome and a flag that marks a wrong final guess. The global history advances at lookup time with the guessed outcome. After a wrong guess it is rebuilt from the returned snapshot, so that younger wrong-path guesses leave no trace in it.

Top module: `tourn_pred`

## Requirements
- R1: Each direction and chooser entry is a 2-bit saturating counter. Values 0 and 1 mean not-taken and values 2 and 3 mean taken. Training with taken adds one and stops at 3. Training with not-taken subtracts one and stops at 0.
- R2: After reset every counter in every table holds 1 and every history holds 0. The first lookup therefore gives not-taken from both components, and `pred_ghist` reads 0.
- R3: The global component's entry is `pc[K+1:2] XOR ghist`. Address bits [1:0] take no part in any index.
- R4: The local component keeps one H-bit history per address index `pc[A+1:2]`. Training shifts the real outcome into bit 0 of that history. The counter used is entry `{pc[A+1:2], history}` of a table with 2^(A+H) counters.
- R5: The chooser entry `pc[K+1:2]` selects the global guess (`pred_comp0`) when its bit 1 is 0, and the local guess (`pred_comp1`) when its bit 1 is 1.
- R6: In training, the chooser counter goes up when only the local guess matched the outcome and down when only the global guess matched. It is left as it is when both guesses matched or both missed.
- R7: Each lookup with `pred_valid` high shifts the final guess into bit 0 of the global history. `pred_ghist` shows the history from before that shift, which is also the value used for the R3 index. Without a lookup or a recovery the history holds its value.
- R8: A training beat with `upd_mispredict` high sets the global history to `{upd_ghist[K-2:0], upd_taken}`. This takes priority over a lookup shift in the same cycle.
- R9: Training changes the tables at the next clock edge. A lookup in the same cycle as a training beat to the same entries returns the values from before the training.
- R10: Both component guesses appear on `pred_comp0` and `pred_comp1` in the same cycle as the final guess. When the two agree, the final guess equals them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A lookup is made this cycle |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final direction guess |
| pred_comp0 | output | 1 | Global-history component guess |
| pred_comp1 | output | 1 | Local-history component guess |
| pred_ghist | output | K | Global history snapshot used by this lookup |
| upd_valid | input | 1 | A training beat is present |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the branch |
| upd_comp0 | input | 1 | Global guess made at lookup |
| upd_comp1 | input | 1 | Local guess made at lookup |
| upd_mispredict | input | 1 | The final guess was wrong |
| upd_ghist | input | K | History snapshot taken at lookup |

## Verification
The bench sends a lookup and a training beat to the same entry in one cycle. A design that forwarded the new value would return a guess one training step too early. It forces a recovery and a lookup into the same cycle. A design that let the shift win would leave a wrong-path bit in the history, and every later global index would be off. It drives long taken runs followed by a single not-taken. A counter that wrapped instead of saturating would flip the guess at once, and a chooser trained on every miss instead of only on disagreement would move toward the wrong component. A fixed-seed random mix of addresses and outcomes then checks that address bits [1:0] are ignored and that local histories stay separate per branch.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_WEAK_NT = 2'd1;

   // saturating step toward the observed direction
   function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
      ctr2_t nxt;
      nxt = cur;
      if (taken && cur != 2'd3)
         nxt = cur + 2'd1;
      else if (!taken && cur != 2'd0)
         nxt = cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
   import tourn_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   output logic             rd_msb_raw,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   localparam int DEPTH = 1 << IDX_W;

   ctr2_t cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= CTR_WEAK_NT;
      end else if (wr_en) begin
         cells[wr_idx] <= ctr_step(cells[wr_idx], wr_taken);
      end
   end

   assign rd_taken   = cells[rd_idx][1];
   assign rd_msb_raw = cells[rd_idx][1];
endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
   parameter int IDX_W = 7,
   parameter int H     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [H-1:0]     rd_hist,
   input  logic [IDX_W-1:0] wr_idx,
   output logic [H-1:0]     wr_hist,
   input  logic             wr_en,
   input  logic             wr_taken
);
   localparam int DEPTH = 1 << IDX_W;

   logic [H-1:0] hist [DEPTH];
   logic [H-1:0] shifted;

   assign rd_hist = hist[rd_idx];
   assign wr_hist = hist[wr_idx];

   generate
      if (H == 1) begin : g_h_one
         assign shifted = wr_taken;
      end else begin : g_h_multi
         assign shifted = {wr_hist[H-2:0], wr_taken};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            hist[i] <= '0;
      end else if (wr_en) begin
         hist[wr_idx] <= shifted;
      end
   end
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
   parameter int K = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         shift_bit,
   input  logic         restore_en,
   input  logic [K-1:0] restore_snap,
   input  logic         restore_bit,
   output logic [K-1:0] hist
);
   logic [K-1:0] shift_val;
   logic [K-1:0] restore_val;

   generate
      if (K == 1) begin : g_k_one
         assign shift_val   = shift_bit;
         assign restore_val = restore_bit;
      end else begin : g_k_multi
         assign shift_val   = {hist[K-2:0], shift_bit};
         assign restore_val = {restore_snap[K-2:0], restore_bit};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist <= '0;
      else if (restore_en)
         hist <= restore_val;
      else if (shift_en)
         hist <= shift_val;
   end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
   parameter int PC_W = 32,
   parameter int K    = 10,
   parameter int A    = 7,
   parameter int H    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pred_valid,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   output logic            pred_comp0,
   output logic            pred_comp1,
   output logic [K-1:0]    pred_ghist,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic            upd_comp0,
   input  logic            upd_comp1,
   input  logic            upd_mispredict,
   input  logic [K-1:0]    upd_ghist
);
   localparam int PHT_W = A + H;

   generate
      if (K < 2)         begin : g_bad_k  $error("K must be at least 2");        end
      if (A < 1)         begin : g_bad_a  $error("A must be at least 1");        end
      if (H < 1)         begin : g_bad_h  $error("H must be at least 1");        end
      if (K + 2 > PC_W)  begin : g_bad_kp $error("K index exceeds PC width");    end
      if (A + 2 > PC_W)  begin : g_bad_ap $error("A index exceeds PC width");    end
   endgenerate

   // lookup-side indices
   logic [K-1:0]     p_addr_k;
   logic [A-1:0]     p_addr_a;
   logic [H-1:0]     p_lhist;
   logic             meta_hi;
   logic             meta_unused;
   logic             g_unused;
   logic             l_unused;

   // training-side indices
   logic [K-1:0]     u_addr_k;
   logic [A-1:0]     u_addr_a;
   logic [H-1:0]     u_lhist;
   logic             c0_ok;
   logic             c1_ok;
   logic             mis_fix;

   assign p_addr_k = pred_pc[K+1:2];
   assign p_addr_a = pred_pc[A+1:2];
   assign u_addr_k = upd_pc[K+1:2];
   assign u_addr_a = upd_pc[A+1:2];
   assign c0_ok    = (upd_comp0 == upd_taken);
   assign c1_ok    = (upd_comp1 == upd_taken);
   assign mis_fix  = upd_valid && upd_mispredict;

   tp_ghist #(.K(K)) u_ghist (
      .clk          (clk),
      .rst_n        (rst_n),
      .shift_en     (pred_valid),
      .shift_bit    (pred_taken),
      .restore_en   (mis_fix),
      .restore_snap (upd_ghist),
      .restore_bit  (upd_taken),
      .hist         (pred_ghist)
   );

   tp_ctr_table #(.IDX_W(K)) u_gshare (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (p_addr_k ^ pred_ghist),
      .rd_taken   (pred_comp0),
      .rd_msb_raw (g_unused),
      .wr_en      (upd_valid),
      .wr_idx     (u_addr_k ^ upd_ghist),
      .wr_taken   (upd_taken)
   );

   tp_local_hist #(.IDX_W(A), .H(H)) u_bht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (p_addr_a),
      .rd_hist  (p_lhist),
      .wr_idx   (u_addr_a),
      .wr_hist  (u_lhist),
      .wr_en    (upd_valid),
      .wr_taken (upd_taken)
   );

   tp_ctr_table #(.IDX_W(PHT_W)) u_pht (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     ({p_addr_a, p_lhist}),
      .rd_taken   (pred_comp1),
      .rd_msb_raw (l_unused),
      .wr_en      (upd_valid),
      .wr_idx     ({u_addr_a, u_lhist}),
      .wr_taken   (upd_taken)
   );

   // chooser: trained only when exactly one component was right
   tp_ctr_table #(.IDX_W(K)) u_meta (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (p_addr_k),
      .rd_taken   (meta_hi),
      .rd_msb_raw (meta_unused),
      .wr_en      (upd_valid && (c0_ok != c1_ok)),
      .wr_idx     (u_addr_k),
      .wr_taken   (c1_ok)
   );

   assign pred_taken = meta_hi ? pred_comp1 : pred_comp0;
endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
   parameter int K = 10
) (
   input logic         clk,
   input logic         rst_n,
   input logic         pred_valid,
   input logic         pred_taken,
   input logic         pred_comp0,
   input logic         pred_comp1,
   input logic [K-1:0] pred_ghist,
   input logic         upd_valid,
   input logic         upd_taken,
   input logic         upd_mispredict,
   input logic [K-1:0] upd_ghist
);
   AST_GHR_SPEC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && !(upd_valid && upd_mispredict)) |=>
      (pred_ghist == {$past(pred_ghist[K-2:0]), $past(pred_taken)})); // R7

   AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pred_valid && !(upd_valid && upd_mispredict)) |=> $stable(pred_ghist)); // R7

   AST_GHR_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_mispredict) |=>
      (pred_ghist == {$past(upd_ghist[K-2:0]), $past(upd_taken)})); // R8

   AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_comp0 == pred_comp1) |-> (pred_taken == pred_comp0)); // R10

   AST_PICK_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken == pred_comp0) || (pred_taken == pred_comp1)); // R5
endmodule

bind tourn_pred tourn_pred_chk #(.K(K)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pred_valid     (pred_valid),
   .pred_taken     (pred_taken),
   .pred_comp0     (pred_comp0),
   .pred_comp1     (pred_comp1),
   .pred_ghist     (pred_ghist),
   .upd_valid      (upd_valid),
   .upd_taken      (upd_taken),
   .upd_mispredict (upd_mispredict),
   .upd_ghist      (upd_ghist)
);

// File: tb/tourn_pred_tb.sv
module tourn_pred_tb;
   localparam int PC_W = 32;
   localparam int K    = 10;
   localparam int A    = 7;
   localparam int H    = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pred_valid = 1'b0;
   logic [PC_W-1:0] pred_pc = '0;
   logic            pred_taken, pred_comp0, pred_comp1;
   logic [K-1:0]    pred_ghist;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0, upd_comp0 = 1'b0, upd_comp1 = 1'b0;
   logic            upd_mispredict = 1'b0;
   logic [K-1:0]    upd_ghist = '0;

   always #5 clk = ~clk;

   tourn_pred #(.PC_W(PC_W), .K(K), .A(A), .H(H)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_comp0(pred_comp0), .pred_comp1(pred_comp1), .pred_ghist(pred_ghist),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_comp0(upd_comp0), .upd_comp1(upd_comp1),
      .upd_mispredict(upd_mispredict), .upd_ghist(upd_ghist)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model built from the requirements
   logic [1:0]   m_g    [1 << K];
   logic [1:0]   m_meta [1 << K];
   logic [1:0]   m_pht  [1 << (A + H)];
   logic [H-1:0] m_bht  [1 << A];
   logic [K-1:0] m_ghr;

   logic [K+2:0] exp_q [$];
   string        tag_q [$];

   function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
      if (t) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < (1 << K); i++) begin m_g[i] = 2'd1; m_meta[i] = 2'd1; end
      for (int i = 0; i < (1 << (A + H)); i++) m_pht[i] = 2'd1;
      for (int i = 0; i < (1 << A); i++) m_bht[i] = '0;
      m_ghr = '0;
   endtask

   task automatic step(input logic pv, input logic [PC_W-1:0] ppc,
                       input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                       input logic uc0, input logic uc1, input logic umis,
                       input logic [K-1:0] uck, input string tag,
                       output logic et, output logic ec0, output logic ec1,
                       output logic [K-1:0] eck);
      logic [K-1:0] gi, ui;
      logic [A-1:0] li, uli;
      @(negedge clk);
      pred_valid = pv; pred_pc = ppc;
      upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_comp0 = uc0;
      upd_comp1 = uc1; upd_mispredict = umis; upd_ghist = uck;
      // expected lookup from state before this edge (R9)
      gi  = ppc[K+1:2] ^ m_ghr;
      li  = ppc[A+1:2];
      ec0 = m_g[gi][1];
      ec1 = m_pht[{li, m_bht[li]}][1];
      et  = m_meta[ppc[K+1:2]][1] ? ec1 : ec0;
      eck = m_ghr;
      if (pv) begin
         exp_q.push_back({et, ec0, ec1, eck});
         tag_q.push_back(tag);
      end
      // model training
      if (uv) begin
         ui  = upc[K+1:2] ^ uck;
         uli = upc[A+1:2];
         m_g[ui] = sat(m_g[ui], ut);
         m_pht[{uli, m_bht[uli]}] = sat(m_pht[{uli, m_bht[uli]}], ut);
         m_bht[uli] = {m_bht[uli][H-2:0], ut};
         if ((uc0 == ut) != (uc1 == ut))
            m_meta[upc[K+1:2]] = sat(m_meta[upc[K+1:2]], uc1 == ut);
      end
      if (uv && umis) m_ghr = {uck[K-2:0], ut};
      else if (pv)    m_ghr = {m_ghr[K-2:0], et};
   endtask

   task automatic idle();
      logic a, b, c; logic [K-1:0] d;
      step(0, '0, 0, '0, 0, 0, 0, 0, '0, "", a, b, c, d);
   endtask

   // lookup, then train with the real outcome one cycle later
   task automatic branch(input logic [PC_W-1:0] pc, input logic actual, input string tag);
      logic et, ec0, ec1, a, b, c;
      logic [K-1:0] eck, d;
      step(1, pc, 0, '0, 0, 0, 0, 0, '0, tag, et, ec0, ec1, eck);
      step(0, '0, 1, pc, actual, ec0, ec1, et != actual, eck, tag, a, b, c, d);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      logic [K+2:0] exp_v, got_v;
      string tg;
      #2;
      if (exp_q.size() > 0) begin
         exp_v = exp_q.pop_front();
         tg    = tag_q.pop_front();
         got_v = {pred_taken, pred_comp0, pred_comp1, pred_ghist};
         checks++;
         if (got_v !== exp_v) begin
            errors++;
            $display("FAIL %s: got taken/c0/c1/ghist=%b expected %b", tg, got_v, exp_v);
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic et1, c01, c11, et2, c02, c12, x, y, z;
      logic [K-1:0] ck1, ck2, w;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset history visible before any lookup
      checks++;
      if (pred_ghist !== '0) begin
         errors++;
         $display("FAIL R2: got ghist=%b expected 0", pred_ghist);
      end
      branch(32'h0000_1000, 1'b1, "R2");

      // R1: long taken run saturates, single not-taken keeps taken guess
      for (int i = 0; i < 8; i++) branch(32'h0000_2040, 1'b1, "R1");
      branch(32'h0000_2040, 1'b0, "R1");
      branch(32'h0000_2040, 1'b1, "R1");
      for (int i = 0; i < 6; i++) branch(32'h0000_2040, 1'b0, "R1");

      // R3: low address bits ignored
      for (int i = 0; i < 4; i++) branch(32'h0000_3100 | i, i[0], "R3");

      // R4 / R6: alternating branch lets local history win the chooser
      for (int i = 0; i < 24; i++) branch(32'h0000_4204, i[0], "R4");
      for (int i = 0; i < 12; i++) begin
         branch(32'h0000_4204, i[0], "R6");
         branch(32'h0000_5308, 1'b1, "R6");
      end

      // R8: recovery and lookup in the same cycle
      step(1, 32'h0000_6000, 0, '0, 0, 0, 0, 0, '0, "R8", et1, c01, c11, ck1);
      step(1, 32'h0000_6010, 0, '0, 0, 0, 0, 0, '0, "R8", et2, c02, c12, ck2);
      step(1, 32'h0000_6020, 1, 32'h0000_6000, !et1, c01, c11, 1'b1, ck1, "R8", x, y, z, w);
      step(1, 32'h0000_6030, 0, '0, 0, 0, 0, 0, '0, "R8", x, y, z, w);
      idle();

      // R9: training and lookup to the same branch in one cycle
      step(1, 32'h0000_7000, 0, '0, 0, 0, 0, 0, '0, "R9", et1, c01, c11, ck1);
      step(1, 32'h0000_7000, 1, 32'h0000_7000, 1'b1, c01, c11, et1 != 1'b1, ck1, "R9",
           et2, c02, c12, ck2);
      step(1, 32'h0000_7000, 1, 32'h0000_7000, 1'b1, c02, c12, et2 != 1'b1, ck2, "R9",
           x, y, z, w);
      idle();

      // R5 / R10: fixed-seed random mix
      void'($urandom(32'd77));
      for (int i = 0; i < 400; i++) begin
         logic [PC_W-1:0] pc;
         pc = {20'h0, 3'($urandom_range(0, 7)), 9'($urandom_range(0, 511))};
         branch(pc, 1'($urandom_range(0, 1)), (i % 2) ? "R5" : "R10");
      end

      repeat (4) idle();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule